// File: doc/BRIEF.md
# Translation Unit Control and Interrupt Register Block

This block is the software-visible control face of a small two-level address translation unit. A 32-bit register port, addressed by byte offset, reaches a directory base register, a status word, a command register, the address of the most recent fault, a port that invalidates one cached translation, and an interrupt group: raw status, enable mask, masked status and a write-ones-to-clear register. One further register holds an automatic clock gating enable. The page-walk datapath lives outside the block and talks to it through a fault report handshake, two invalidate pulses, a release pulse and a pair of status inputs.

Commands written to the command register drive three state flags: translation on, walker held (stall) and fault pending. A stall may only be requested while translation is on. A fault from the walker is accepted only while translation is on and no earlier fault is pending, and it stays pending until software sends the fault-handled command. The force-reset command returns every register and flag to zero in a single write.

The fault report is a valid/ready channel. The walker raises `flt_valid` with `flt_va` and `flt_is_write` and must hold all three steady until it sees `flt_ready` high at a clock edge. `flt_ready` is high only while translation is on and no fault is pending, so a second fault waits until the first one has been handled. The register port has no back-pressure: a write takes effect at the clock edge it is presented on, and a read returns its data with `reg_rvalid` one cycle later.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: After reset, the directory base, fault address, raw status, mask, masked status and gating registers read zero, the status word reads bit 31 set and bits 0, 1, 2 and 5 clear, and `irq`, `paging_en`, `stall_en` and `clk_gate_en` are low. A read returns its data with `reg_rvalid` on the cycle after `reg_rd`.
- R2: The directory base at offset 0x00 keeps bits 31:12 of the written word, and bits 11:0 read back as zero.
- R3: Writing command 0 to offset 0x08 turns translation on (status bit 0, `paging_en`). Command 1 turns it off and also drops any stall. The command register reads back as zero.
- R4: Command 2 sets stall (status bit 2, `stall_en`) only while translation is on and is ignored otherwise. Command 3 clears stall and leaves translation on. Status bit 31 always reads as the inverse of bit 2.
- R5: A fault from the walker is accepted at an edge where `flt_valid` and `flt_ready` are both high. It sets status bit 1 (fault pending), loads status bit 5 with the write flag, stores the address at offset 0x0C and sets raw interrupt bit 0. `flt_ready` is high only while translation is on and no fault is pending.
- R6: Command 5 clears the pending fault and the write flag and raises `flt_release` for exactly one cycle.
- R7: Command 4 raises `inv_all` for one cycle, on the cycle after the write. A write to offset 0x10 raises `inv_one` for one cycle, on the cycle after the write, with `inv_one_va` equal to the written word.
- R8: `bus_err` sets raw interrupt bit 1. Raw status is at offset 0x14 and the mask at offset 0x1C. Masked status at offset 0x20 reads raw AND mask, and `irq` is the OR of the masked bits. A write to offset 0x20 has no effect.
- R9: Writing ones to offset 0x18 clears those raw bits. When a new event arrives in the same cycle as a clear of its bit, the bit stays set.
- R10: Command 6 returns every register and flag to zero: directory base, fault address, raw status, mask, gating, translation, stall and fault pending. Command words other than 0 to 6 have no effect.
- R11: Bit 0 of offset 0x24 drives `clk_gate_en`, and only that bit reads back.
- R12: Status bit 3 reflects the `walker_idle` input and status bit 4 reflects the `replay_empty` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| flt_valid | input | 1 | Walker fault report valid |
| flt_ready | output | 1 | Block can accept a fault report |
| flt_va | input | 32 | Faulting virtual address |
| flt_is_write | input | 1 | Faulting access was a write |
| bus_err | input | 1 | Walker bus read error event |
| walker_idle | input | 1 | Walker has no work in flight |
| replay_empty | input | 1 | Walker replay buffer is empty |
| paging_en | output | 1 | Translation enabled |
| stall_en | output | 1 | Walker hold requested |
| flt_release | output | 1 | One-cycle release of a walker held on a fault |
| inv_all | output | 1 | One-cycle invalidate of the whole translation cache |
| inv_one | output | 1 | One-cycle invalidate of one translation |
| inv_one_va | output | 32 | Virtual address for inv_one |
| clk_gate_en | output | 1 | Automatic clock gating enable |
| irq | output | 1 | Interrupt request, OR of masked status |

## Verification
The bench builds the block with its default parameters: a 32-bit data word, an 8-bit byte offset, a 12-bit page shift and two interrupt sources. With these values every field position named in the requirements is reachable. The directory base masking can be seen on the 12 low bits, and both interrupt sources can be raised, masked and cleared one at a time or together. The bench also covers the case where a clear and a new event land in the same cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // Register byte offsets (decoded by software, so the positions are fixed)
  localparam logic [7:0] OFF_DIR_BASE = 8'h00;
  localparam logic [7:0] OFF_STATUS   = 8'h04;
  localparam logic [7:0] OFF_COMMAND  = 8'h08;
  localparam logic [7:0] OFF_FLT_ADDR = 8'h0C;
  localparam logic [7:0] OFF_INV_ONE  = 8'h10;
  localparam logic [7:0] OFF_IRQ_RAW  = 8'h14;
  localparam logic [7:0] OFF_IRQ_CLR  = 8'h18;
  localparam logic [7:0] OFF_IRQ_MASK = 8'h1C;
  localparam logic [7:0] OFF_IRQ_STAT = 8'h20;
  localparam logic [7:0] OFF_GATING   = 8'h24;

  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    OP_XLAT_ON   = 3'd0,
    OP_XLAT_OFF  = 3'd1,
    OP_HOLD_ON   = 3'd2,
    OP_HOLD_OFF  = 3'd3,
    OP_FLUSH_ALL = 3'd4,
    OP_FLT_DONE  = 3'd5,
    OP_WIPE      = 3'd6
  } op_e;
endpackage

// File: rtl/xlat_mode_fsm.sv
module xlat_mode_fsm
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [CMD_W-1:0] op_code,
  input  logic             wipe,
  input  logic             flt_take,
  input  logic             flt_wr_in,
  output logic             xlat_on,
  output logic             hold_on,
  output logic             flt_pend,
  output logic             flt_wr,
  output logic             release_p,
  output logic             flush_p
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat_on   <= 1'b0;
      hold_on   <= 1'b0;
      flt_pend  <= 1'b0;
      flt_wr    <= 1'b0;
      release_p <= 1'b0;
      flush_p   <= 1'b0;
    end else if (wipe) begin
      xlat_on   <= 1'b0;
      hold_on   <= 1'b0;
      flt_pend  <= 1'b0;
      flt_wr    <= 1'b0;
      release_p <= 1'b0;
      flush_p   <= 1'b0;
    end else begin
      release_p <= 1'b0;
      flush_p   <= 1'b0;
      if (flt_take) begin
        flt_pend <= 1'b1;
        flt_wr   <= flt_wr_in;
      end
      if (op_valid) begin
        case (op_code)
          OP_XLAT_ON:   xlat_on <= 1'b1;
          OP_XLAT_OFF: begin
            xlat_on <= 1'b0;
            hold_on <= 1'b0;
          end
          OP_HOLD_ON:   if (xlat_on) hold_on <= 1'b1;
          OP_HOLD_OFF:  hold_on <= 1'b0;
          OP_FLUSH_ALL: flush_p <= 1'b1;
          OP_FLT_DONE: begin
            flt_pend  <= 1'b0;
            flt_wr    <= 1'b0;
            release_p <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/xlat_irq_bank.sv
module xlat_irq_bank #(
  parameter int SRC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wipe,
  input  logic [SRC_N-1:0] evt,
  input  logic             clr_we,
  input  logic [SRC_N-1:0] clr_bits,
  input  logic             msk_we,
  input  logic [SRC_N-1:0] msk_bits,
  output logic [SRC_N-1:0] raw,
  output logic [SRC_N-1:0] msk,
  output logic [SRC_N-1:0] hit,
  output logic             irq
);
  logic [SRC_N-1:0] raw_nx;

  always_comb begin
    raw_nx = raw;
    if (clr_we) raw_nx = raw_nx & ~clr_bits;
    raw_nx = raw_nx | evt;   // fresh events outrank a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw <= '0;
      msk <= '0;
    end else if (wipe) begin
      raw <= '0;
      msk <= '0;
    end else begin
      raw <= raw_nx;
      if (msk_we) msk <= msk_bits;
    end
  end

  assign hit = raw & msk;
  assign irq = |hit;
endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
  import xlat_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SRC_N      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              flt_valid,
  output logic              flt_ready,
  input  logic [DATA_W-1:0] flt_va,
  input  logic              flt_is_write,
  input  logic              bus_err,
  input  logic              walker_idle,
  input  logic              replay_empty,
  output logic              paging_en,
  output logic              stall_en,
  output logic              flt_release,
  output logic              inv_all,
  output logic              inv_one,
  output logic [DATA_W-1:0] inv_one_va,
  output logic              clk_gate_en,
  output logic              irq
);
  localparam int BASE_W = DATA_W - PAGE_SHIFT;

  logic [ADDR_W-1:0] off;
  assign off = reg_addr;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] o);
    return a == ADDR_W'(o);
  endfunction

  logic op_valid, wipe, flt_take;
  logic flt_pend, flt_wr;
  logic [SRC_N-1:0] raw, msk, hit;

  assign op_valid = reg_wr && at(off, OFF_COMMAND) && (reg_wdata[DATA_W-1:CMD_W] == '0);
  assign wipe     = op_valid && (reg_wdata[CMD_W-1:0] == OP_WIPE);
  assign flt_ready = paging_en && !flt_pend;
  assign flt_take  = flt_valid && flt_ready;

  xlat_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (reg_wdata[CMD_W-1:0]),
    .wipe      (wipe),
    .flt_take  (flt_take),
    .flt_wr_in (flt_is_write),
    .xlat_on   (paging_en),
    .hold_on   (stall_en),
    .flt_pend  (flt_pend),
    .flt_wr    (flt_wr),
    .release_p (flt_release),
    .flush_p   (inv_all)
  );

  logic [SRC_N-1:0] evt;
  assign evt = SRC_N'({bus_err, flt_take});

  xlat_irq_bank #(.SRC_N(SRC_N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wipe     (wipe),
    .evt      (evt),
    .clr_we   (reg_wr && at(off, OFF_IRQ_CLR)),
    .clr_bits (reg_wdata[SRC_N-1:0]),
    .msk_we   (reg_wr && at(off, OFF_IRQ_MASK)),
    .msk_bits (reg_wdata[SRC_N-1:0]),
    .raw      (raw),
    .msk      (msk),
    .hit      (hit),
    .irq      (irq)
  );

  // Plain storage registers
  logic [BASE_W-1:0] dir_base;
  logic [DATA_W-1:0] flt_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_base    <= '0;
      flt_addr    <= '0;
      clk_gate_en <= 1'b0;
      inv_one     <= 1'b0;
      inv_one_va  <= '0;
    end else if (wipe) begin
      dir_base    <= '0;
      flt_addr    <= '0;
      clk_gate_en <= 1'b0;
      inv_one     <= 1'b0;
    end else begin
      inv_one <= 1'b0;
      if (reg_wr && at(off, OFF_DIR_BASE)) dir_base <= reg_wdata[DATA_W-1:PAGE_SHIFT];
      if (reg_wr && at(off, OFF_GATING))   clk_gate_en <= reg_wdata[0];
      if (reg_wr && at(off, OFF_INV_ONE)) begin
        inv_one    <= 1'b1;
        inv_one_va <= reg_wdata;
      end
      if (flt_take) flt_addr <= flt_va;
    end
  end

  // Status word assembly
  logic [DATA_W-1:0] status_w;
  always_comb begin
    status_w           = '0;
    status_w[0]        = paging_en;
    status_w[1]        = flt_pend;
    status_w[2]        = stall_en;
    status_w[3]        = walker_idle;
    status_w[4]        = replay_empty;
    status_w[5]        = flt_wr;
    status_w[DATA_W-1] = !stall_en;
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (at(off, OFF_DIR_BASE))      rd_mux = {dir_base, {PAGE_SHIFT{1'b0}}};
    else if (at(off, OFF_STATUS))   rd_mux = status_w;
    else if (at(off, OFF_FLT_ADDR)) rd_mux = flt_addr;
    else if (at(off, OFF_IRQ_RAW))  rd_mux = DATA_W'(raw);
    else if (at(off, OFF_IRQ_MASK)) rd_mux = DATA_W'(msk);
    else if (at(off, OFF_IRQ_STAT)) rd_mux = DATA_W'(hit);
    else if (at(off, OFF_GATING))   rd_mux = DATA_W'(clk_gate_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/xlat_ctrl_regs_chk.sv
module xlat_ctrl_regs_chk
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_rvalid,
  input logic              flt_valid,
  input logic              flt_ready,
  input logic              paging_en,
  input logic              stall_en,
  input logic              inv_one,
  input logic [DATA_W-1:0] inv_one_va,
  input logic              irq
);
  AST_STALL_NEEDS_PAGING: assert property (@(posedge clk) disable iff (!rst_n)
    stall_en |-> paging_en); // R4

  AST_STATUS_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_W'(OFF_STATUS)) |=> (reg_rvalid && (reg_rdata[DATA_W-1] != reg_rdata[2]))); // R4

  AST_INV_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_INV_ONE)) |=> (inv_one && inv_one_va == $past(reg_wdata))); // R7

  AST_ONE_FAULT_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_ready) |=> !flt_ready); // R5

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFF_COMMAND) && reg_wdata == DATA_W'(6)) |=> (!paging_en && !stall_en && !irq)); // R10
endmodule

bind xlat_ctrl_regs xlat_ctrl_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .flt_valid  (flt_valid),
  .flt_ready  (flt_ready),
  .paging_en  (paging_en),
  .stall_en   (stall_en),
  .inv_one    (inv_one),
  .inv_one_va (inv_one_va),
  .irq        (irq)
);

// File: tb/xlat_ctrl_regs_tb.sv
`timescale 1ns/1ps
module xlat_ctrl_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        flt_valid = 0, flt_is_write = 0, bus_err = 0;
  logic [31:0] flt_va = '0;
  logic        flt_ready;
  logic        walker_idle = 1, replay_empty = 1;
  logic        paging_en, stall_en, flt_release, inv_all, inv_one, clk_gate_en, irq;
  logic [31:0] inv_one_va;

  always #4 clk = ~clk;   // 125 MHz

  xlat_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .flt_valid(flt_valid), .flt_ready(flt_ready), .flt_va(flt_va),
    .flt_is_write(flt_is_write), .bus_err(bus_err), .walker_idle(walker_idle),
    .replay_empty(replay_empty), .paging_en(paging_en), .stall_en(stall_en),
    .flt_release(flt_release), .inv_all(inv_all), .inv_one(inv_one),
    .inv_one_va(inv_one_va), .clk_gate_en(clk_gate_en), .irq(irq)
  );

  int checks = 0, failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops one expected word per returned read
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) check("R1 unexpected rvalid", 32'h1, 32'h0);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic cmd(input logic [31:0] c);
    wr(8'h08, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R12 reset state
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 paging_en", {31'b0, paging_en}, 0);
    check("R1 clk_gate_en", {31'b0, clk_gate_en}, 0);
    rd(8'h04, 32'h8000_0018, "R1 R12 status");
    rd(8'h00, 0, "R1 dir base");
    rd(8'h1C, 0, "R1 mask");
    rd(8'h14, 0, "R1 raw");
    walker_idle = 0;
    rd(8'h04, 32'h8000_0010, "R12 idle low");
    walker_idle = 1;
    // R2
    wr(8'h00, 32'hCAFE_BABE);
    rd(8'h00, 32'hCAFE_B000, "R2 dir base mask");
    // R4 stall refused with translation off
    cmd(2);
    rd(8'h04, 32'h8000_0018, "R4 stall ignored");
    // R3
    cmd(0);
    rd(8'h04, 32'h8000_0019, "R3 paging on");
    rd(8'h08, 0, "R3 command reads zero");
    check("R3 paging_en", {31'b0, paging_en}, 1);
    // R4
    cmd(2);
    rd(8'h04, 32'h0000_001D, "R4 stall on");
    check("R4 stall_en", {31'b0, stall_en}, 1);
    cmd(3);
    rd(8'h04, 32'h8000_0019, "R4 stall off keeps paging");
    cmd(2); cmd(1);
    rd(8'h04, 32'h8000_0018, "R3 paging off drops stall");
    cmd(0);
    // R5 fault handshake
    wr(8'h1C, 3);
    @(negedge clk); flt_valid = 1; flt_va = 32'h1234_5678; flt_is_write = 1;
    check("R5 ready before", {31'b0, flt_ready}, 1);
    @(negedge clk); flt_valid = 0;
    check("R5 ready after", {31'b0, flt_ready}, 0);
    check("R8 irq on fault", {31'b0, irq}, 1);
    rd(8'h04, 32'h8000_003B, "R5 status fault");
    rd(8'h0C, 32'h1234_5678, "R5 fault addr");
    rd(8'h14, 1, "R5 raw bit0");
    wr(8'h20, 0);
    rd(8'h20, 1, "R8 masked ignores write");
    // R6
    cmd(5);
    check("R6 release pulse", {31'b0, flt_release}, 1);
    @(negedge clk);
    check("R6 release one cycle", {31'b0, flt_release}, 0);
    rd(8'h04, 32'h8000_0019, "R6 fault cleared");
    // R9
    wr(8'h18, 1);
    rd(8'h14, 0, "R9 clear");
    check("R9 irq low", {31'b0, irq}, 0);
    // R8 bus error and masking
    @(negedge clk); bus_err = 1;
    @(negedge clk); bus_err = 0;
    rd(8'h14, 2, "R8 raw bus err");
    wr(8'h1C, 1);
    rd(8'h20, 0, "R8 masked off");
    check("R8 irq masked", {31'b0, irq}, 0);
    wr(8'h1C, 3);
    check("R8 irq unmasked", {31'b0, irq}, 1);
    // R9 event beats clear
    @(negedge clk); reg_wr = 1; reg_addr = 8'h18; reg_wdata = 2; bus_err = 1;
    @(negedge clk); reg_wr = 0; bus_err = 0;
    rd(8'h14, 2, "R9 event wins");
    // R7
    wr(8'h10, 32'hABCD_E000);
    check("R7 inv_one", {31'b0, inv_one}, 1);
    check("R7 inv_one_va", inv_one_va, 32'hABCD_E000);
    @(negedge clk);
    check("R7 inv_one one cycle", {31'b0, inv_one}, 0);
    cmd(4);
    check("R7 inv_all", {31'b0, inv_all}, 1);
    @(negedge clk);
    check("R7 inv_all one cycle", {31'b0, inv_all}, 0);
    // R11
    wr(8'h24, 32'h0000_FFFF);
    rd(8'h24, 1, "R11 gating read");
    check("R11 clk_gate_en", {31'b0, clk_gate_en}, 1);
    // R10 unknown and wipe
    cmd(7); cmd(32'h100);
    rd(8'h04, 32'h8000_0019, "R10 unknown ignored");
    cmd(6);
    rd(8'h00, 0, "R10 dir base wiped");
    rd(8'h14, 0, "R10 raw wiped");
    rd(8'h1C, 0, "R10 mask wiped");
    rd(8'h0C, 0, "R10 fault addr wiped");
    rd(8'h24, 0, "R10 gating wiped");
    rd(8'h04, 32'h8000_0018, "R10 status wiped");
    check("R10 paging_en", {31'b0, paging_en}, 0);
    repeat (2) @(negedge clk);
    check("R1 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R1 watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule